// File: doc/BRIEF.md
# Crystal Temperature Compensation Calculator

This block turns one signed temperature reading into a pair of trim codes that cancel the frequency error of a 32.768 kHz tuning-fork crystal. The crystal runs slow by a parabolic amount, error = -alpha * (T - Tturn)^2 ppm, where Tturn is the crystal's turnover temperature. The block computes the opposite correction, adds a fixed trim found at room temperature, and splits the total into a coarse code worth 30.5 ppm per step and a fine code worth 1 ppm per step.

A controller pulses `start_i` with a new temperature. The curvature constant, the turnover temperature and the room trim come in as static values from registers. After a few cycles the block presents both codes and pulses `done_o` once. It uses one shared multiplier: the first pass forms the square of the temperature offset, and the second pass scales it by alpha. A short loop then peels off whole coarse steps.

Top module: `xtal_tcomp_calc`

## Requirements
- R1: After a synchronous active-low reset, `fine_o` and `coarse_o` are 0 and `done_o` is low.
- R2: For d = temp_i - turn_i, with alpha_i unsigned in units of 1/1024 ppm/°C², the total correction in half-ppm units is C = floor((alpha_i*d*d + 256)/512) + 2*init_trim_i. Positive codes raise the frequency.
- R3: `coarse_o` is sign(C) * min(floor(|C|/61), 10), a signed value in the range -10..+10.
- R4: `fine_o` is floor((Rm + 1)/2), where Rm = C - 61*coarse_o, saturated to the range -31..+32.
- R5: `done_o` is high for exactly one cycle per result. `fine_o` and `coarse_o` hold their values until the next result.
- R6: `done_o` rises 4 + |coarse_o| clock cycles after the edge that samples `start_i`.
- R7: A `start_i` pulse arriving while a calculation is in progress is ignored, so each accepted start yields exactly one result. A start in the cycle where `done_o` is high is accepted.
- R8: When |coarse_o| < 10, `fine_o` lies within -30..+30. It is not negative when `coarse_o` > 0 and not positive when `coarse_o` < 0.
- R9: Temperatures at equal distances above and below the turnover temperature give identical codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request that samples `temp_i` |
| temp_i | input | 8 | Signed temperature in °C |
| turn_i | input | 8 | Signed turnover temperature in °C |
| alpha_i | input | 10 | Unsigned curvature constant, LSB = 1/1024 ppm/°C² |
| init_trim_i | input | 7 | Signed room-temperature fine trim in ppm |
| fine_o | output | 7 | Signed fine trim code, 1 ppm per step |
| coarse_o | output | 5 | Signed coarse trim code, 30.5 ppm per step |
| done_o | output | 1 | One-cycle pulse when both codes are new |

## Verification
Every result is due exactly 4 + |coarse| cycles after the edge that samples the start. The delay therefore ranges from 4 cycles for a small correction to 14 cycles when the coarse code saturates. The driver records the cycle number of that sampling edge alongside the expected codes. The monitor samples on the falling edge and checks the measured delay against the expected coarse magnitude. Starts issued during a calculation and starts issued in the done cycle confirm that results appear only for accepted starts.

// File: rtl/xtal_tcomp_pkg.sv
// Package: shared types for the temperature compensation calculator.
// Assumes a single clock domain; the state encoding is internal only.
package xtal_tcomp_pkg;

    // Sequencer states, one per pass through the shared datapath
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SQR  = 3'd1,
        ST_PRD  = 3'd2,
        ST_SUM  = 3'd3,
        ST_DIV  = 3'd4
    } tc_state_e;

    // Load strobes from the sequencer to the datapath
    typedef struct packed {
        logic ld_diff;
        logic ld_sq;
        logic ld_prod;
        logic ld_mag;
        logic div_en;
    } tc_ctrl_t;

endpackage

// File: rtl/xtal_tcomp_fsm.sv
// Sequencer: walks one request through square, scale, sum and step split.
// Assumes div_last_i is high in ST_DIV once no more coarse steps can be
// removed; starts outside ST_IDLE are dropped.
module xtal_tcomp_fsm
    import xtal_tcomp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     div_last_i,
    output tc_ctrl_t ctrl_o
);

    tc_state_e st_q, st_d;

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_i) st_d = ST_SQR;
            ST_SQR:  st_d = ST_PRD;
            ST_PRD:  st_d = ST_SUM;
            ST_SUM:  st_d = ST_DIV;
            ST_DIV:  if (div_last_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Decode datapath strobes from the current state
    always_comb begin
        ctrl_o.ld_diff = (st_q == ST_IDLE) && start_i;
        ctrl_o.ld_sq   = (st_q == ST_SQR);
        ctrl_o.ld_prod = (st_q == ST_PRD);
        ctrl_o.ld_mag  = (st_q == ST_SUM);
        ctrl_o.div_en  = (st_q == ST_DIV);
    end

endmodule

// File: rtl/xtal_tcomp_mult.sv
// Shared unsigned multiplier used for both the square and the alpha scale.
// Assumes operands are already aligned by the caller; purely combinational.
module xtal_tcomp_mult #(
    parameter int A_W = 10,
    parameter int B_W = 16
) (
    input  logic [A_W-1:0]     a_i,
    input  logic [B_W-1:0]     b_i,
    output logic [A_W+B_W-1:0] p_o
);

    // Full-width product
    assign p_o = a_i * b_i;

endmodule

// File: rtl/xtal_tcomp_errpath.sv
// Error path: offset from turnover, its square, the alpha scaling, rounding
// to half-ppm and the room trim. One multiplier is time-shared between the
// square (ST_SQR) and the scale (ST_PRD). Assumes alpha_i, turn_i and
// init_trim_i stay steady while a request is in flight.
module xtal_tcomp_errpath
    import xtal_tcomp_pkg::*;
#(
    parameter int TW   = 8,
    parameter int AW   = 10,
    parameter int TRW  = 7,
    parameter int FRAC = 10,
    parameter int CW   = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  tc_ctrl_t             ctrl_i,
    input  logic [TW-1:0]        temp_i,
    input  logic [TW-1:0]        turn_i,
    input  logic [AW-1:0]        alpha_i,
    input  logic [TRW-1:0]       init_trim_i,
    output logic signed [CW-1:0] corr_o
);

    localparam int MW  = TW;
    localparam int SQW = 2 * MW;
    localparam int OAW = (AW > MW) ? AW : MW;
    localparam int PW  = AW + SQW;
    localparam int HW  = PW - FRAC + 2;
    localparam logic [PW:0] RND = (PW+1)'(1) << (FRAC - 2);

    logic signed [TW:0]   diff;
    logic [MW-1:0]        mag_d, mag_q;
    logic [SQW-1:0]       sq_q;
    logic [PW-1:0]        prod_q;
    logic [OAW-1:0]       op_a;
    logic [SQW-1:0]       op_b;
    logic [OAW+SQW-1:0]   mul_p;
    logic [HW-1:0]        half_mag;
    logic signed [CW-1:0] trim2;

    // Signed offset from the turnover point and its magnitude
    always_comb begin
        diff  = $signed({temp_i[TW-1], temp_i}) - $signed({turn_i[TW-1], turn_i});
        mag_d = diff[TW] ? MW'(-diff) : MW'(diff);
    end

    // Operand steering for the shared multiplier
    always_comb begin
        if (ctrl_i.ld_sq) begin
            op_a = OAW'(mag_q);
            op_b = SQW'(mag_q);
        end else begin
            op_a = OAW'(alpha_i);
            op_b = sq_q;
        end
    end

    xtal_tcomp_mult #(
        .A_W (OAW),
        .B_W (SQW)
    ) mult_i (
        .a_i (op_a),
        .b_i (op_b),
        .p_o (mul_p)
    );

    // Pipeline registers for offset, square and scaled product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q  <= '0;
            sq_q   <= '0;
            prod_q <= '0;
        end else begin
            if (ctrl_i.ld_diff) mag_q  <= mag_d;
            if (ctrl_i.ld_sq)   sq_q   <= mul_p[SQW-1:0];
            if (ctrl_i.ld_prod) prod_q <= mul_p[PW-1:0];
        end
    end

    // Round to nearest half-ppm and add twice the room trim
    always_comb begin
        half_mag = HW'(({1'b0, prod_q} + RND) >> (FRAC - 1));
        trim2    = {{(CW-TRW-1){init_trim_i[TRW-1]}}, init_trim_i, 1'b0};
        corr_o   = $signed({{(CW-HW){1'b0}}, half_mag}) + trim2;
    end

endmodule

// File: rtl/xtal_tcomp_split.sv
// Step splitter: removes whole coarse steps (STEP_HALF half-ppm each) from
// the correction magnitude one per cycle, up to COARSE_MAX, then rounds the
// remainder to 1 ppm and saturates it into the fine range. Assumes the
// correction magnitude is below 2^(CW-1).
module xtal_tcomp_split
    import xtal_tcomp_pkg::*;
#(
    parameter int CW         = 19,
    parameter int STEP_HALF  = 61,
    parameter int COARSE_MAX = 10,
    parameter int FINE_MAX   = 32,
    parameter int FINE_MIN   = -31,
    parameter int FW         = 7,
    parameter int CRW        = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tc_ctrl_t              ctrl_i,
    input  logic signed [CW-1:0]  corr_i,
    output logic                  div_last_o,
    output logic signed [FW-1:0]  fine_o,
    output logic signed [CRW-1:0] coarse_o,
    output logic                  done_o
);

    localparam int SW = $clog2(COARSE_MAX + 1);
    localparam logic signed [CW-1:0] ONE_S  = CW'(1);
    localparam logic signed [CW-1:0] LIM_HI = CW'(FINE_MAX);
    localparam logic signed [CW-1:0] LIM_LO = CW'(FINE_MIN);

    logic [CW-1:0]         mag_q;
    logic                  neg_q;
    logic [SW-1:0]         steps_q;
    logic                  can_sub;
    logic signed [CW-1:0]  rem_s, half_up;
    logic signed [FW-1:0]  fine_d;
    logic signed [CRW-1:0] coarse_mag, coarse_d;

    // Another coarse step may be taken while budget and magnitude allow
    assign can_sub    = (mag_q >= CW'(STEP_HALF)) && (steps_q < SW'(COARSE_MAX));
    assign div_last_o = ~can_sub;

    // Signed remainder, rounded to 1 ppm and saturated
    always_comb begin
        rem_s   = neg_q ? -$signed(mag_q) : $signed(mag_q);
        half_up = (rem_s + ONE_S) >>> 1;
        if (half_up > LIM_HI)      fine_d = FW'(FINE_MAX);
        else if (half_up < LIM_LO) fine_d = FW'(FINE_MIN);
        else                       fine_d = FW'(half_up);
    end

    // Signed coarse code from the step count
    always_comb begin
        coarse_mag = $signed({1'b0, steps_q});
        coarse_d   = neg_q ? -coarse_mag : coarse_mag;
    end

    // Magnitude capture and step removal loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q   <= '0;
            neg_q   <= 1'b0;
            steps_q <= '0;
        end else if (ctrl_i.ld_mag) begin
            neg_q   <= corr_i[CW-1];
            mag_q   <= corr_i[CW-1] ? CW'(-corr_i) : CW'(corr_i);
            steps_q <= '0;
        end else if (ctrl_i.div_en && can_sub) begin
            mag_q   <= mag_q - CW'(STEP_HALF);
            steps_q <= steps_q + SW'(1);
        end
    end

    // Result registers and the one-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_o   <= '0;
            coarse_o <= '0;
            done_o   <= 1'b0;
        end else if (ctrl_i.div_en && !can_sub) begin
            fine_o   <= fine_d;
            coarse_o <= coarse_d;
            done_o   <= 1'b1;
        end else begin
            done_o   <= 1'b0;
        end
    end

endmodule

// File: rtl/xtal_tcomp_calc.sv
// Top: crystal temperature compensation calculator. Accepts one temperature
// per start pulse, returns a fine (1 ppm) and coarse (30.5 ppm) trim pair
// with a one-cycle done pulse. Assumes the register-sourced inputs are
// steady from start until done.
module xtal_tcomp_calc
    import xtal_tcomp_pkg::*;
#(
    parameter  int TEMP_W     = 8,
    parameter  int ALPHA_W    = 10,
    parameter  int TRIM_W     = 7,
    parameter  int ALPHA_FRAC = 10,
    parameter  int STEP_HALF  = 61,
    parameter  int COARSE_MAX = 10,
    parameter  int FINE_MAX   = 32,
    parameter  int FINE_MIN   = -31,
    localparam int FINE_W     = $clog2(FINE_MAX + 1) + 1,
    localparam int COARSE_W   = $clog2(COARSE_MAX + 1) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic signed [TEMP_W-1:0]   temp_i,
    input  logic signed [TEMP_W-1:0]   turn_i,
    input  logic [ALPHA_W-1:0]         alpha_i,
    input  logic signed [TRIM_W-1:0]   init_trim_i,
    output logic signed [FINE_W-1:0]   fine_o,
    output logic signed [COARSE_W-1:0] coarse_o,
    output logic                       done_o
);

    localparam int PROD_W = ALPHA_W + 2 * TEMP_W;
    localparam int HALF_W = PROD_W - ALPHA_FRAC + 2;
    localparam int CORR_W = ((HALF_W > TRIM_W + 1) ? HALF_W : TRIM_W + 1) + 1;

    tc_ctrl_t                   ctrl;
    logic                       div_last;
    logic signed [CORR_W-1:0]   corr;

    xtal_tcomp_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .div_last_i (div_last),
        .ctrl_o     (ctrl)
    );

    xtal_tcomp_errpath #(
        .TW   (TEMP_W),
        .AW   (ALPHA_W),
        .TRW  (TRIM_W),
        .FRAC (ALPHA_FRAC),
        .CW   (CORR_W)
    ) err_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .temp_i      (temp_i),
        .turn_i      (turn_i),
        .alpha_i     (alpha_i),
        .init_trim_i (init_trim_i),
        .corr_o      (corr)
    );

    xtal_tcomp_split #(
        .CW         (CORR_W),
        .STEP_HALF  (STEP_HALF),
        .COARSE_MAX (COARSE_MAX),
        .FINE_MAX   (FINE_MAX),
        .FINE_MIN   (FINE_MIN),
        .FW         (FINE_W),
        .CRW        (COARSE_W)
    ) split_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .corr_i     (corr),
        .div_last_o (div_last),
        .fine_o     (fine_o),
        .coarse_o   (coarse_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/xtal_tcomp_calc_chk.sv
// Checker: port-level properties of the calculator. It keeps its own record
// of an outstanding request and its age to judge result timing.
module xtal_tcomp_calc_chk #(
    parameter int FINE_W     = 7,
    parameter int COARSE_W   = 5,
    parameter int FINE_MAX   = 32,
    parameter int FINE_MIN   = -31,
    parameter int COARSE_MAX = 10,
    parameter int STEP_HALF  = 61
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start_i,
    input logic                       done_o,
    input logic signed [FINE_W-1:0]   fine_o,
    input logic signed [COARSE_W-1:0] coarse_o
);

    localparam int BAND     = (STEP_HALF - 1) / 2;
    localparam int LAT_BASE = 4;

    logic                       pend_q;
    logic [7:0]                 age_q;
    logic                       past_ok_q;
    logic signed [COARSE_W-1:0] c_abs;

    assign c_abs = (coarse_o < 0) ? -coarse_o : coarse_o;

    // Track the accepted request and cycles elapsed since its start edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            age_q     <= '0;
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
            if (start_i && (!pend_q || done_o)) begin
                pend_q <= 1'b1;
                age_q  <= '0;
            end else if (done_o) begin
                pend_q <= 1'b0;
            end else if (pend_q && age_q != 8'hFF) begin
                age_q  <= age_q + 8'd1;
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !done_o) |-> ($stable(fine_o) && $stable(coarse_o)));

    assert_fine_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fine_o <= FINE_MAX && fine_o >= FINE_MIN));

    assert_coarse_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (coarse_o <= COARSE_MAX && coarse_o >= -COARSE_MAX));

    assert_fine_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_abs < COARSE_MAX) |-> (fine_o <= BAND && fine_o >= -BAND));

    assert_sign_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && coarse_o > 0) |-> (fine_o >= 0));

    assert_sign_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && coarse_o < 0) |-> (fine_o <= 0));

    assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pend_q);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (age_q == 8'(c_abs) + 8'(LAT_BASE)));

endmodule

bind xtal_tcomp_calc xtal_tcomp_calc_chk #(
    .FINE_W     (FINE_W),
    .COARSE_W   (COARSE_W),
    .FINE_MAX   (FINE_MAX),
    .FINE_MIN   (FINE_MIN),
    .COARSE_MAX (COARSE_MAX),
    .STEP_HALF  (STEP_HALF)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .fine_o   (fine_o),
    .coarse_o (coarse_o)
);

// File: tb/xtal_tcomp_calc_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected codes, the monitor pops and
// compares them whenever a result pulse is seen.
module xtal_tcomp_calc_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [7:0] temp = '0;
    logic signed [7:0] turn = '0;
    logic [9:0]        alpha = '0;
    logic signed [6:0] trim = '0;
    logic signed [6:0] fine;
    logic signed [4:0] coarse;
    logic              done;

    typedef struct {
        int    fine;
        int    coarse;
        int    lat;
        int    t0;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;
    int   dones = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    xtal_tcomp_calc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .temp_i      (temp),
        .turn_i      (turn),
        .alpha_i     (alpha),
        .init_trim_i (trim),
        .fine_o      (fine),
        .coarse_o    (coarse),
        .done_o      (done)
    );

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Reference model written from R2, R3, R4 and R6
    function automatic exp_t model(int t, int t0, int a, int tr, int stc, string tag);
        exp_t e;
        int d, p, c, k, cs, r, f;
        d  = t - t0;
        p  = a * d * d;
        c  = (p + 256) / 512 + 2 * tr;
        k  = ((c < 0) ? -c : c) / 61;
        if (k > 10) k = 10;
        cs = (c < 0) ? -k : k;
        r  = c - 61 * cs;
        f  = (r + 1) >>> 1;
        if (f > 32)  f = 32;
        if (f < -31) f = -31;
        e.fine = f; e.coarse = cs; e.lat = 4 + k; e.t0 = stc; e.tag = tag;
        return e;
    endfunction

    task automatic issue(int t, int t0, int a, int tr, string tag);
        @(negedge clk);
        temp  = 8'(t);
        turn  = 8'(t0);
        alpha = 10'(a);
        trim  = 7'(tr);
        start = 1'b1;
        exp_q.push_back(model(t, t0, a, tr, cyc + 1, tag));
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares each result against the head of the queue
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            dones++;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 unexpected result actual=%0d/%0d expected=none", fine, coarse);
            end else begin
                e = exp_q.pop_front();
                check({"R4 fine ", e.tag}, int'(fine), e.fine);
                check({"R3 coarse ", e.tag}, int'(coarse), e.coarse);
                check({"R6 latency ", e.tag}, cyc - e.t0, e.lat);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset fine", int'(fine), 0);
        check("R1 reset coarse", int'(coarse), 0);
        check("R1 reset done", int'(done), 0);

        issue(25, 25, 35, 0, "R2 at turnover");            drain();
        issue(25, 25, 35, 5, "R2 room trim only");          drain();
        issue(25, 25, 35, -31, "R3 negative one step");     drain();
        issue(-40, 25, 35, 0, "R2 cold");                   drain();
        issue(90, 25, 35, 0, "R9 mirror hot");              drain();
        issue(1, 0, 255, 0, "R2 round below half");         drain();
        issue(1, 0, 256, 0, "R2 round at half");            drain();
        issue(10, 0, 305, 0, "R8 sixty half-ppm");          drain();
        issue(10, 0, 310, 0, "R3 exactly one step");        drain();
        issue(0, 0, 0, -64, "R4 most negative trim");       drain();
        issue(127, -128, 1023, 0, "R4 positive saturation"); drain();
        issue(-128, 127, 1023, -64, "R9 mirror saturation"); drain();

        for (int i = 0; i < 24; i++) begin
            issue(-60 + i * 7, 20 + (i % 3) * 3, (30 + i * 17) % 200, (i % 9) - 4, "R2 sweep");
            drain();
        end

        // R7: a second start during the calculation is dropped
        d0 = dones;
        issue(-40, 25, 35, 0, "R7 first of overlap");
        @(negedge clk);
        temp  = 8'sd100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        check("R7 one result for overlapping starts", dones - d0, 1);

        // R7: a start in the done cycle is accepted
        d0 = dones;
        issue(-20, 25, 40, 3, "R7 before back-to-back");
        do @(negedge clk); while (!done);
        temp  = 8'sd70;
        start = 1'b1;
        exp_q.push_back(model(70, 25, 40, 3, cyc + 1, "R7 back-to-back"));
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        check("R7 two results for back-to-back", dones - d0, 2);
        check("R5 outputs held", int'(fine), model(70, 25, 40, 3, 0, "").fine);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule